// File: doc/BRIEF.md
# Bit-Time Timestamp Counter with Network Synchronization

This block keeps a 16-bit time base that advances once per bus bit time rather than once per clock. A separate bit-timing unit supplies a single-cycle strobe at each bit boundary; while the counter is enabled, every such strobe adds one. The count wraps from its top value back to zero and never saturates.

When the protocol engine reports that a frame was received or transmitted successfully, it raises a one-cycle event strobe together with the index of the message buffer involved. The block then latches the current count as a timestamp and presents it on the next cycle. With the timestamp it presents a valid strobe, the buffer index and the direction, so that the logic writing buffer RAM can store the stamp next to the message.

With synchronization switched on, traffic in buffer 0 also clears the counter. Every node on the bus clears on the same frame, so all nodes share a common time base. Buffer 0 still receives the value the counter held before the clear. A one-cycle sync pulse reports each clear.

Top module: `bittime_stamp_unit`

## Requirements
- R1: Out of reset, `count_o` is 0, and `stamp_valid_o` and `sync_pulse_o` are both 0.
- R2: When `count_en` and `bit_tick` are both 1 in a cycle and no sync clear occurs, `count_o` is one higher on the next cycle.
- R3: When `count_en` is 0 or `bit_tick` is 0 and no sync clear occurs, `count_o` keeps its value.
- R4: A tick at count 0xFFFF gives 0x0000 (wrap, no saturation).
- R5: A cycle with `rx_done`=1 makes `stamp_valid_o`=1 on the next cycle only, with `stamp_o` equal to the count in the event cycle, `stamp_buf_o` equal to `evt_buf`, and `stamp_is_tx_o`=0.
- R6: A cycle with `tx_done`=1 and `rx_done`=0 captures in the same way, with `stamp_is_tx_o`=1.
- R7: When `sync_en`=1 and an event occurs with `evt_buf`=0, `count_o` is 0 and `sync_pulse_o` is 1 on the next cycle. The clear works even while `count_en` is 0.
- R8: The timestamp from a sync event holds the count from before the clear.
- R9: If a bit tick coincides with a sync clear, the count becomes 0, not 1.
- R10: With `sync_en`=0, or with a buffer index other than 0, an event leaves the count unchanged apart from normal ticking, and `sync_pulse_o` stays 0.
- R11: While `count_en`=0, the count does not move on ticks, and a capture returns the held value.
- R12: If `rx_done` and `tx_done` are both 1 in one cycle, exactly one capture is made and it is marked as a receive (`stamp_is_tx_o`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe per bus bit time |
| count_en | input | 1 | Counting enable |
| sync_en | input | 1 | Allow buffer-0 traffic to clear the counter |
| rx_done | input | 1 | Successful reception strobe |
| tx_done | input | 1 | Successful transmission strobe |
| evt_buf | input | 4 | Buffer index of the event |
| count_o | output | 16 | Live counter value |
| stamp_o | output | 16 | Captured timestamp |
| stamp_valid_o | output | 1 | Timestamp valid, one cycle |
| stamp_buf_o | output | 4 | Buffer index of the captured stamp |
| stamp_is_tx_o | output | 1 | 1 = stamp from a transmission |
| sync_pulse_o | output | 1 | Counter was cleared by sync |

## Verification
The counter is driven in several ways: ticks on every cycle, sparse ticks, ticks with the enable low, and a full run to 0xFFFF and over. Together these separate incrementing from holding and from wrapping. Capture events are sent as a receive, as a transmit, as both at once, and with the counter disabled, so that the direction flag, the receive precedence and the held value are each shown on their own. Sync events are tried in buffer 0 against another buffer, and with sync on against sync off, and once together with a bit tick. This tells the clear condition apart and shows that the reset wins over the tick and that the pre-clear stamp is kept.

// File: rtl/bts_pkg.sv
package bts_pkg;
    typedef enum logic {
        EV_RX = 1'b0,
        EV_TX = 1'b1
    } ev_kind_e;
endpackage

// File: rtl/bts_count_core.sv
module bts_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             clear,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } core_s;

    core_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.cnt = '0;
        end else if (en && tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/bts_capture.sv
module bts_capture
    import bts_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int BUF_W    = 4,
    parameter int SYNC_BUF = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_done,
    input  logic             tx_done,
    input  logic [BUF_W-1:0] evt_buf,
    input  logic             sync_en,
    input  logic [CNT_W-1:0] count,
    output logic             clear_req,
    output logic [CNT_W-1:0] stamp,
    output logic             stamp_valid,
    output logic [BUF_W-1:0] stamp_buf,
    output logic             stamp_is_tx,
    output logic             sync_pulse
);
    localparam logic [BUF_W-1:0] SYNC_IDX = BUF_W'(SYNC_BUF);

    typedef struct packed {
        logic [CNT_W-1:0] stamp;
        logic             valid;
        logic [BUF_W-1:0] buf_idx;
        ev_kind_e         kind;
        logic             sync;
    } cap_s;

    cap_s st_d, st_q;
    logic evt_hit;

    assign evt_hit   = rx_done || tx_done;
    assign clear_req = sync_en && evt_hit && (evt_buf == SYNC_IDX);

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.sync  = clear_req;
        if (evt_hit) begin
            // count is the pre-update value, so a sync stamp keeps the old time
            st_d.stamp   = count;
            st_d.valid   = 1'b1;
            st_d.buf_idx = evt_buf;
            st_d.kind    = rx_done ? EV_RX : EV_TX;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stamp       = st_q.stamp;
    assign stamp_valid = st_q.valid;
    assign stamp_buf   = st_q.buf_idx;
    assign stamp_is_tx = (st_q.kind == EV_TX);
    assign sync_pulse  = st_q.sync;
endmodule

// File: rtl/bittime_stamp_unit.sv
module bittime_stamp_unit #(
    parameter int CNT_W    = 16,
    parameter int BUF_W    = 4,
    parameter int SYNC_BUF = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             count_en,
    input  logic             sync_en,
    input  logic             rx_done,
    input  logic             tx_done,
    input  logic [BUF_W-1:0] evt_buf,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] stamp_o,
    output logic             stamp_valid_o,
    output logic [BUF_W-1:0] stamp_buf_o,
    output logic             stamp_is_tx_o,
    output logic             sync_pulse_o
);
    logic clear_req;

    bts_count_core #(.CNT_W(CNT_W)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (bit_tick),
        .en    (count_en),
        .clear (clear_req),
        .count (count_o)
    );

    bts_capture #(
        .CNT_W    (CNT_W),
        .BUF_W    (BUF_W),
        .SYNC_BUF (SYNC_BUF)
    ) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_done     (rx_done),
        .tx_done     (tx_done),
        .evt_buf     (evt_buf),
        .sync_en     (sync_en),
        .count       (count_o),
        .clear_req   (clear_req),
        .stamp       (stamp_o),
        .stamp_valid (stamp_valid_o),
        .stamp_buf   (stamp_buf_o),
        .stamp_is_tx (stamp_is_tx_o),
        .sync_pulse  (sync_pulse_o)
    );
endmodule

// File: rtl/bittime_stamp_unit_chk.sv
module bittime_stamp_unit_chk #(
    parameter int CNT_W    = 16,
    parameter int BUF_W    = 4,
    parameter int SYNC_BUF = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_tick,
    input logic             count_en,
    input logic             sync_en,
    input logic             rx_done,
    input logic             tx_done,
    input logic [BUF_W-1:0] evt_buf,
    input logic [CNT_W-1:0] count_o,
    input logic [CNT_W-1:0] stamp_o,
    input logic             stamp_valid_o,
    input logic             stamp_is_tx_o,
    input logic             sync_pulse_o
);
    logic ev, sync_ev;
    assign ev      = rx_done || tx_done;
    assign sync_ev = sync_en && ev && (evt_buf == BUF_W'(SYNC_BUF));

    // R2
    count_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && bit_tick && !sync_ev) |=> (count_o == $past(count_o) + 1'b1));
    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(count_en && bit_tick) && !sync_ev) |=> $stable(count_o));
    // R5
    stamp_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> (stamp_valid_o && stamp_o == $past(count_o)));
    // R5
    stamp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ev |=> !stamp_valid_o);
    // R7
    sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_ev |=> (count_o == '0 && sync_pulse_o));
    // R10
    sync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_ev |=> !sync_pulse_o);
    // R12
    rx_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !stamp_is_tx_o);
endmodule

bind bittime_stamp_unit bittime_stamp_unit_chk #(
    .CNT_W(CNT_W), .BUF_W(BUF_W), .SYNC_BUF(SYNC_BUF)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .count_en(count_en),
    .sync_en(sync_en), .rx_done(rx_done), .tx_done(tx_done), .evt_buf(evt_buf),
    .count_o(count_o), .stamp_o(stamp_o), .stamp_valid_o(stamp_valid_o),
    .stamp_is_tx_o(stamp_is_tx_o), .sync_pulse_o(sync_pulse_o)
);

// File: tb/tb_bittime_stamp_unit.sv
module tb_bittime_stamp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0, count_en = 1'b0, sync_en = 1'b0;
    logic        rx_done = 1'b0, tx_done = 1'b0;
    logic [3:0]  evt_buf = '0;
    logic [15:0] count_o, stamp_o;
    logic        stamp_valid_o, stamp_is_tx_o, sync_pulse_o;
    logic [3:0]  stamp_buf_o;

    int n_run = 0, n_fail = 0;
    logic [15:0] held;

    always #5 clk = ~clk;

    bittime_stamp_unit dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .count_en(count_en),
        .sync_en(sync_en), .rx_done(rx_done), .tx_done(tx_done), .evt_buf(evt_buf),
        .count_o(count_o), .stamp_o(stamp_o), .stamp_valid_o(stamp_valid_o),
        .stamp_buf_o(stamp_buf_o), .stamp_is_tx_o(stamp_is_tx_o),
        .sync_pulse_o(sync_pulse_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // drive one cycle of inputs; returns at the following negedge
    task automatic cyc(input logic tk, input logic en, input logic se,
                       input logic rx, input logic tx, input logic [3:0] b);
        bit_tick = tk; count_en = en; sync_en = se;
        rx_done = rx; tx_done = tx; evt_buf = b;
        @(negedge clk);
        bit_tick = 0; rx_done = 0; tx_done = 0;
    endtask

    task automatic zero_counter();
        cyc(0, 1, 1, 1, 0, 4'd0);
        cyc(0, 1, 0, 0, 0, 4'd0);
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 count", count_o, 0);
        chk("R1 valid", stamp_valid_o, 0);
        chk("R1 sync", sync_pulse_o, 0);
    endtask

    task automatic t_count();
        for (int i = 0; i < 5; i++) cyc(1, 1, 0, 0, 0, 0);
        chk("R2 dense ticks", count_o, 5);
        cyc(0, 1, 0, 0, 0, 0);
        cyc(1, 1, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 0);
        chk("R3 sparse ticks", count_o, 6);
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0, 0);
        chk("R3 ticks while disabled", count_o, 6);
    endtask

    task automatic t_capture();
        cyc(0, 1, 1, 1, 0, 4'd3);
        chk("R5 rx valid", stamp_valid_o, 1);
        chk("R5 rx stamp", stamp_o, 6);
        chk("R5 rx buf", stamp_buf_o, 3);
        chk("R5 rx dir", stamp_is_tx_o, 0);
        chk("R10 other buffer no clear", count_o, 6);
        chk("R10 other buffer no pulse", sync_pulse_o, 0);
        cyc(1, 1, 0, 0, 0, 0);
        chk("R5 valid one cycle", stamp_valid_o, 0);
        cyc(1, 1, 0, 0, 1, 4'd9);
        chk("R6 tx valid", stamp_valid_o, 1);
        chk("R6 tx stamp", stamp_o, 7);
        chk("R6 tx buf", stamp_buf_o, 9);
        chk("R6 tx dir", stamp_is_tx_o, 1);
        chk("R2 tick during capture", count_o, 8);
        cyc(0, 1, 0, 1, 1, 4'd5);
        chk("R12 both valid", stamp_valid_o, 1);
        chk("R12 both dir rx", stamp_is_tx_o, 0);
        cyc(0, 1, 0, 0, 0, 0);
        chk("R12 single capture", stamp_valid_o, 0);
    endtask

    task automatic t_sync();
        cyc(0, 1, 0, 1, 0, 4'd0);
        chk("R10 sync off no clear", count_o, 8);
        chk("R10 sync off no pulse", sync_pulse_o, 0);
        cyc(0, 1, 1, 0, 1, 4'd0);
        chk("R7 clear", count_o, 0);
        chk("R7 pulse", sync_pulse_o, 1);
        chk("R8 pre-clear stamp", stamp_o, 8);
        cyc(0, 1, 0, 0, 0, 0);
        chk("R7 pulse one cycle", sync_pulse_o, 0);
        for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 0, 0);
        cyc(1, 1, 1, 1, 0, 4'd0);
        chk("R9 tick vs clear", count_o, 0);
        chk("R8 stamp before tick clear", stamp_o, 3);
        for (int i = 0; i < 2; i++) cyc(1, 1, 0, 0, 0, 0);
        cyc(0, 0, 1, 1, 0, 4'd0);
        chk("R7 clear while disabled", count_o, 0);
    endtask

    task automatic t_disabled_capture();
        for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 0, 0);
        held = count_o;
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, 0);
        chk("R11 held", count_o, held);
        cyc(1, 0, 0, 0, 1, 4'd2);
        chk("R11 stamp of held", stamp_o, held);
        chk("R11 count still held", count_o, held);
    endtask

    task automatic t_wrap();
        zero_counter();
        for (int i = 0; i < 65535; i++) cyc(1, 1, 0, 0, 0, 0);
        chk("R4 top value", count_o, 16'hFFFF);
        cyc(1, 1, 0, 0, 0, 0);
        chk("R4 wrap", count_o, 0);
    endtask

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_count();
        t_capture();
        t_sync();
        t_disabled_capture();
        t_wrap();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule